// File: doc/BRIEF.md
# AHB Read Burst Planner

This block turns one read request, given as a word-aligned start address and a word count, into a series of AHB master read transfers. It then returns the fetched words as a plain valid/data stream. The burst type of every transfer comes from a small encoded maximum-length setting and a precise-burst switch. Both are captured when the request is accepted.

With precise bursts off, the planner uses whatever the setting allows and may close a request with a short undefined-length INCR of two or three beats. With precise bursts on, only SINGLE and the fixed-length INCR bursts appear on the bus. A short tail is then rounded up to an INCR4, and the words fetched past the requested count are dropped before they reach the stream. No burst crosses a 1 KB address boundary. An optional lock output holds the bus for the whole request.

A requester presents `req_valid` with the address, count and configuration. The request is taken in the cycle where `req_ready` is also high. Read data leaves on `out_valid`/`out_data` in the same cycle that the slave completes the data phase.

Top module: `rd_burst_planner`

## Requirements
- R1: The maximum-length field `cfg_max_len` is valid only at 0, 1, 4, 8 or 16. `req_ready` is high only when the block is idle and the field is valid. A request presented with any other value is not accepted, and no bus activity follows.
- R2: With setting 0 and precise mode off, every burst is undefined-length INCR (HBURST 3'b001). Each burst covers all remaining words up to the next 1 KB boundary, so no extra word is fetched.
- R3: With setting 1, every transfer is SINGLE (HBURST 3'b000), one per requested word.
- R4: With setting 4, 8 or 16 and precise mode off, each burst is the largest of INCR16 (3'b111), INCR8 (3'b101) and INCR4 (3'b011) that exceeds none of these: the setting, the words still to fetch, the words left before the boundary. If fewer than 4 words remain, 1 word goes as SINGLE and 2 or 3 words go as one INCR of that length.
- R5: With precise mode on, only SINGLE, INCR4, INCR8 and INCR16 are issued. A tail shorter than 4 words is issued as INCR4 when 4 words fit before the boundary, and as SINGLE otherwise. Setting 0 with precise mode on acts as a limit of 16.
- R6: The output stream carries exactly the requested number of words, in address order. Each word equals HRDATA of its beat. `out_valid` is high only in a cycle where HREADY completes that beat's data phase. Surplus beats never produce `out_valid`.
- R7: No burst crosses a 1 KB address boundary. A beat at a boundary address always starts a new burst with NONSEQ.
- R8: HTRANS (IDLE 2'b00, NONSEQ 2'b10, SEQ 2'b11) is NONSEQ on the first beat of a burst and SEQ on later beats. The address and control are held while HREADY is low. A burst starts only in a cycle with `hgrant` high.
- R9: When the lock enable is captured set, `hlock` is high from the cycle after acceptance until the request completes. Otherwise it stays low.
- R10: Configuration is captured at acceptance, and changes on the configuration inputs have no effect until the request completes. `req_ready` returns in the cycle after the last data phase. A request with count 0 completes without any bus activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Request accepted this cycle when both are high |
| req_addr | input | AW | Word-aligned byte start address |
| req_len | input | LW | Number of words to read |
| cfg_max_len | input | 5 | Encoded maximum burst length (0, 1, 4, 8, 16) |
| cfg_precise | input | 1 | Precise-burst mode with surplus discard |
| cfg_lock | input | 1 | Lock enable for the whole request |
| htrans | output | 2 | AHB transfer type |
| hburst | output | 3 | AHB burst type |
| haddr | output | AW | AHB address |
| hlock | output | 1 | AHB lock request |
| hready | input | 1 | AHB transfer done |
| hrdata | input | DW | AHB read data |
| hgrant | input | 1 | Bus granted to this master |
| out_valid | output | 1 | Output word valid |
| out_data | output | DW | Output word |

## Verification
The address-phase outputs depend only on registered state plus `hgrant`. They are therefore due in the first cycle after acceptance and in the cycle after each accepted beat. The output word is due in the same cycle as the HREADY that ends the following data phase, with no register in between. `req_ready` returns one cycle after the last data phase. A behavioural model in the bench keeps the planned beats in a queue and tracks the pending data phase. Mid-cycle it predicts HTRANS, HADDR, HBURST, HLOCK, `req_ready` and the output pair, and it compares them with the design in that same cycle. Stalls and grant gaps shift every later deadline together in model and design alike.

// File: rtl/rbp_pkg.sv
`timescale 1ns/1ps
package rbp_pkg;

    typedef enum logic [1:0] {
        TR_IDLE   = 2'b00,
        TR_BUSY   = 2'b01,
        TR_NONSEQ = 2'b10,
        TR_SEQ    = 2'b11
    } htrans_e;

    localparam logic [2:0] HB_SINGLE = 3'b000;
    localparam logic [2:0] HB_INCR   = 3'b001;
    localparam logic [2:0] HB_INCR4  = 3'b011;
    localparam logic [2:0] HB_INCR8  = 3'b101;
    localparam logic [2:0] HB_INCR16 = 3'b111;

    // How a request is cut into bursts once its setting is decoded
    typedef enum logic [1:0] {
        MODE_UNDEF  = 2'd0,
        MODE_SINGLE = 2'd1,
        MODE_FIXED  = 2'd2
    } bmode_e;

endpackage

// File: rtl/rbp_cfg_dec.sv
`timescale 1ns/1ps
module rbp_cfg_dec
    import rbp_pkg::*;
(
    input  logic [4:0] max_len,
    input  logic       precise,
    output logic       valid,
    output bmode_e     mode,
    output logic [4:0] cap
);

    always_comb begin
        valid = 1'b1;
        mode  = MODE_SINGLE;
        cap   = 5'd1;
        case (max_len)
            5'd0: begin
                if (precise) begin
                    mode = MODE_FIXED;
                    cap  = 5'd16;
                end else begin
                    mode = MODE_UNDEF;
                    cap  = 5'd0;
                end
            end
            5'd1: begin
                mode = MODE_SINGLE;
                cap  = 5'd1;
            end
            5'd4, 5'd8, 5'd16: begin
                mode = MODE_FIXED;
                cap  = max_len;
            end
            default: valid = 1'b0;
        endcase
    end

endmodule

// File: rtl/rbp_sizer.sv
`timescale 1ns/1ps
module rbp_sizer
    import rbp_pkg::*;
#(
    parameter int LW = 8,
    parameter int BW = 9
) (
    input  logic [LW-1:0] rem,
    input  logic [BW-2:0] idx,
    input  bmode_e        mode,
    input  logic [4:0]    cap,
    input  logic          precise,
    output logic [BW-1:0] beats,
    output logic [2:0]    burst
);

    localparam int CW = (LW > BW) ? LW : BW;

    logic [CW-1:0] lim_w;
    logic [CW-1:0] rem_w;
    logic [CW-1:0] avail;

    always_comb begin
        lim_w = (CW'(1) << (BW - 1)) - CW'(idx);
        rem_w = CW'(rem);
        avail = (rem_w < lim_w) ? rem_w : lim_w;

        beats = BW'(1);
        burst = HB_SINGLE;
        case (mode)
            MODE_UNDEF: begin
                beats = BW'(avail);
                burst = HB_INCR;
            end
            MODE_FIXED: begin
                if (cap >= 5'd16 && avail >= CW'(16)) begin
                    beats = BW'(16);
                    burst = HB_INCR16;
                end else if (cap >= 5'd8 && avail >= CW'(8)) begin
                    beats = BW'(8);
                    burst = HB_INCR8;
                end else if (avail >= CW'(4)) begin
                    beats = BW'(4);
                    burst = HB_INCR4;
                end else if (precise) begin
                    if (lim_w >= CW'(4)) begin
                        beats = BW'(4);
                        burst = HB_INCR4;
                    end
                end else if (avail >= CW'(2)) begin
                    beats = BW'(avail);
                    burst = HB_INCR;
                end
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/rbp_rdpath.sv
`timescale 1ns/1ps
module rbp_rdpath #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hready,
    input  logic          addr_acc,
    input  logic          keep_in,
    input  logic [DW-1:0] hrdata,
    output logic          out_valid,
    output logic [DW-1:0] out_data,
    output logic          pend_next
);

    typedef struct packed {
        logic dp_valid;
        logic dp_keep;
    } dp_t;

    dp_t dp_d, dp_q;

    always_comb begin
        dp_d = dp_q;
        if (hready) begin
            dp_d.dp_valid = addr_acc;
            dp_d.dp_keep  = addr_acc & keep_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dp_q <= '0;
        else        dp_q <= dp_d;
    end

    assign out_valid = dp_q.dp_valid & dp_q.dp_keep & hready;
    assign out_data  = hrdata;
    assign pend_next = dp_d.dp_valid;

endmodule

// File: rtl/rd_burst_planner.sv
`timescale 1ns/1ps
module rd_burst_planner
    import rbp_pkg::*;
#(
    parameter int AW          = 32,
    parameter int DW          = 32,
    parameter int LW          = 8,
    parameter int BOUND_BYTES = 1024
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [AW-1:0] req_addr,
    input  logic [LW-1:0] req_len,
    input  logic [4:0]    cfg_max_len,
    input  logic          cfg_precise,
    input  logic          cfg_lock,
    output logic [1:0]    htrans,
    output logic [2:0]    hburst,
    output logic [AW-1:0] haddr,
    output logic          hlock,
    input  logic          hready,
    input  logic [DW-1:0] hrdata,
    input  logic          hgrant,
    output logic          out_valid,
    output logic [DW-1:0] out_data
);

    localparam int BYTES = DW / 8;
    localparam int OFS   = $clog2(BYTES);
    localparam int BND_W = $clog2(BOUND_BYTES) - OFS;
    localparam int BW    = BND_W + 1;

    typedef struct packed {
        logic          busy;
        logic [AW-1:0] addr;
        logic [LW-1:0] rem;
        logic [BW-1:0] beats;
        logic [2:0]    burst;
        bmode_e        mode;
        logic [4:0]    cap;
        logic          precise;
        logic          lock;
    } st_t;

    st_t st_d, st_q;

    logic          cfg_ok;
    bmode_e        dec_mode;
    logic [4:0]    dec_cap;
    logic [BW-1:0] plan_beats;
    logic [2:0]    plan_burst;
    logic          start_b;
    logic          cont_b;
    logic          addr_acc;
    logic          beat_keep;
    logic          pend_next;
    logic          accept_req;
    logic          cfg_precise_q;

    rbp_cfg_dec u_dec (
        .max_len (cfg_max_len),
        .precise (cfg_precise),
        .valid   (cfg_ok),
        .mode    (dec_mode),
        .cap     (dec_cap)
    );

    rbp_sizer #(.LW(LW), .BW(BW)) u_sizer (
        .rem     (st_q.rem),
        .idx     (st_q.addr[BND_W+OFS-1:OFS]),
        .mode    (st_q.mode),
        .cap     (st_q.cap),
        .precise (st_q.precise),
        .beats   (plan_beats),
        .burst   (plan_burst)
    );

    // Address-phase drive, from registered state and grant only
    always_comb begin
        start_b   = st_q.busy && (st_q.beats == '0) && (st_q.rem != '0) && hgrant;
        cont_b    = st_q.busy && (st_q.beats != '0);
        addr_acc  = hready && (start_b || cont_b);
        beat_keep = (st_q.rem != '0);
        if (start_b) begin
            htrans = TR_NONSEQ;
            hburst = plan_burst;
        end else if (cont_b) begin
            htrans = TR_SEQ;
            hburst = st_q.burst;
        end else begin
            htrans = TR_IDLE;
            hburst = HB_SINGLE;
        end
    end

    rbp_rdpath #(.DW(DW)) u_rdpath (
        .clk       (clk),
        .rst_n     (rst_n),
        .hready    (hready),
        .addr_acc  (addr_acc),
        .keep_in   (beat_keep),
        .hrdata    (hrdata),
        .out_valid (out_valid),
        .out_data  (out_data),
        .pend_next (pend_next)
    );

    assign req_ready  = !st_q.busy && cfg_ok;
    assign accept_req = req_valid && req_ready;

    always_comb begin
        st_d = st_q;
        if (accept_req) begin
            st_d.busy    = (req_len != '0);
            st_d.addr    = req_addr;
            st_d.rem     = req_len;
            st_d.beats   = '0;
            st_d.mode    = dec_mode;
            st_d.cap     = dec_cap;
            st_d.precise = cfg_precise;
            st_d.lock    = cfg_lock;
        end else if (addr_acc) begin
            st_d.addr = st_q.addr + AW'(BYTES);
            if (beat_keep) st_d.rem = st_q.rem - 1'b1;
            if (start_b) begin
                st_d.beats = plan_beats - BW'(1);
                st_d.burst = plan_burst;
            end else begin
                st_d.beats = st_q.beats - BW'(1);
            end
        end
        if (st_q.busy && (st_d.rem == '0) && (st_d.beats == '0) && !pend_next)
            st_d.busy = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.mode <= MODE_SINGLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign haddr         = st_q.addr;
    assign hlock         = st_q.busy && st_q.lock;
    assign cfg_precise_q = st_q.precise;

endmodule

// File: rtl/rbp_sva.sv
`timescale 1ns/1ps
module rbp_sva #(
    parameter int AW          = 32,
    parameter int BOUND_BYTES = 1024
) (
    input logic          clk,
    input logic          rst_n,
    input logic [1:0]    htrans,
    input logic [2:0]    hburst,
    input logic [AW-1:0] haddr,
    input logic          hready,
    input logic          hgrant,
    input logic          hlock,
    input logic          req_ready,
    input logic          out_valid,
    input logic          precise_q
);

    assert_seq_after_beat_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (htrans == 2'b11) |-> ($past(htrans) != 2'b00));

    assert_hold_on_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (htrans == 2'b11 && !hready) |=> (htrans == 2'b11 && $stable(haddr) && $stable(hburst)));

    assert_start_needs_grant_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (htrans == 2'b10) |-> hgrant);

    assert_legal_burst_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (htrans != 2'b00) |-> (hburst == 3'b000 || hburst == 3'b001 || hburst == 3'b011 ||
                               hburst == 3'b101 || hburst == 3'b111));

    assert_no_undef_in_precise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (precise_q && htrans != 2'b00) |-> (hburst != 3'b001));

    assert_no_boundary_cross_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (htrans == 2'b11) |-> ((haddr & AW'(BOUND_BYTES - 1)) != '0));

    assert_out_on_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> hready);

    assert_lock_blocks_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hlock |-> !req_ready);

endmodule

bind rd_burst_planner rbp_sva u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .htrans    (htrans),
    .hburst    (hburst),
    .haddr     (haddr),
    .hready    (hready),
    .hgrant    (hgrant),
    .hlock     (hlock),
    .req_ready (req_ready),
    .out_valid (out_valid),
    .precise_q (cfg_precise_q)
);

// File: tb/sim_rd_burst_planner.sv
`timescale 1ns/1ps
module sim_rd_burst_planner;

    localparam int AW = 32;
    localparam int DW = 32;
    localparam int LW = 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          req_valid;
    logic          req_ready;
    logic [AW-1:0] req_addr;
    logic [LW-1:0] req_len;
    logic [4:0]    cfg_max_len;
    logic          cfg_precise;
    logic          cfg_lock;
    logic [1:0]    htrans;
    logic [2:0]    hburst;
    logic [AW-1:0] haddr;
    logic          hlock;
    logic          hready;
    logic [DW-1:0] hrdata;
    logic          hgrant;
    logic          out_valid;
    logic [DW-1:0] out_data;

    always #2 clk = ~clk;   // 4 ns period

    rd_burst_planner u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_len(req_len), .cfg_max_len(cfg_max_len),
        .cfg_precise(cfg_precise), .cfg_lock(cfg_lock), .htrans(htrans),
        .hburst(hburst), .haddr(haddr), .hlock(hlock), .hready(hready),
        .hrdata(hrdata), .hgrant(hgrant), .out_valid(out_valid), .out_data(out_data)
    );

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    int delivered = 0;
    int grant_low = 0;
    bit rand_rdy = 0;
    bit timed_out = 0;
    string cur_tag = "R4";

    // reference model state
    int unsigned q_addr[$];
    int          q_tr[$];
    int          q_bu[$];
    bit          q_keep[$];
    bit          m_dp_valid = 0;
    bit          m_dp_keep = 0;
    logic [31:0] m_dp_addr = 0;
    bit          m_lock = 0;
    bit          s_valid = 0;
    logic [31:0] s_addr = 0;

    function automatic logic [31:0] fdat(logic [31:0] a);
        return (a * 32'h9E3779B1) ^ 32'h5A5A1234;
    endfunction

    function automatic bit cfg_ok(logic [4:0] v);
        return (v == 0) || (v == 1) || (v == 4) || (v == 8) || (v == 16);
    endfunction

    function automatic bit m_busy();
        return (q_tr.size() > 0) || m_dp_valid;
    endfunction

    function automatic void build(int unsigned addr, int len, int mb, bit prec);
        int rem;
        int unsigned a;
        int lim;
        int avail;
        int n;
        int bu;
        int cap;
        rem = len;
        a = addr;
        while (rem > 0) begin
            lim = 256 - ((a >> 2) & 255);
            avail = (rem < lim) ? rem : lim;
            if (mb == 1) begin n = 1; bu = 0; end
            else if (mb == 0 && !prec) begin n = avail; bu = 1; end
            else begin
                cap = (mb == 0) ? 16 : mb;
                if (cap >= 16 && avail >= 16) begin n = 16; bu = 7; end
                else if (cap >= 8 && avail >= 8) begin n = 8; bu = 5; end
                else if (avail >= 4) begin n = 4; bu = 3; end
                else if (prec) begin
                    if (lim >= 4) begin n = 4; bu = 3; end
                    else begin n = 1; bu = 0; end
                end
                else if (avail >= 2) begin n = avail; bu = 1; end
                else begin n = 1; bu = 0; end
            end
            for (int k = 0; k < n; k++) begin
                q_addr.push_back(a + 4 * k);
                q_tr.push_back((k == 0) ? 2 : 3);
                q_bu.push_back(bu);
                q_keep.push_back(k < rem);
            end
            rem = rem - ((n < rem) ? n : rem);
            a = a + 4 * n;
        end
    endfunction

    task automatic chk(bit ok, string tag, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
        end
    endtask

    task automatic cyc();
        int  etr;
        bit  ev;
        bit  acc_m;
        bit  s_hr;
        bit  s_dacc;
        bit  s_req;
        logic [31:0] s_ha;
        @(negedge clk);
        cycles++;
        etr = 0;
        if (q_tr.size() > 0) etr = (q_tr[0] == 2 && !hgrant) ? 0 : q_tr[0];
        chk(htrans == etr, "R8", "htrans", htrans, etr);
        if (etr != 0) begin
            chk(haddr == q_addr[0], "R7", "haddr", haddr, q_addr[0]);
            chk(hburst == q_bu[0], cur_tag, "hburst", hburst, q_bu[0]);
        end
        ev = m_dp_valid && m_dp_keep && hready;
        chk(out_valid == ev, "R6", "out_valid", out_valid, ev);
        if (ev && out_valid) begin
            chk(out_data == fdat(m_dp_addr), "R6", "out_data", out_data, fdat(m_dp_addr));
            delivered++;
        end
        chk(hlock == (m_busy() && m_lock), "R9", "hlock", hlock, m_busy() && m_lock);
        chk(req_ready == (!m_busy() && cfg_ok(cfg_max_len)), m_busy() ? "R10" : "R1",
            "req_ready", req_ready, !m_busy() && cfg_ok(cfg_max_len));
        s_hr   = hready;
        s_dacc = hready && (htrans != 0);
        s_ha   = haddr;
        s_req  = req_valid && !m_busy() && cfg_ok(cfg_max_len);
        acc_m  = hready && (etr != 0);
        @(posedge clk);
        if (s_hr) begin
            s_valid = s_dacc;
            s_addr  = s_ha;
        end
        if (acc_m) begin
            m_dp_valid = 1;
            m_dp_keep  = q_keep[0];
            m_dp_addr  = q_addr[0];
            void'(q_addr.pop_front());
            void'(q_tr.pop_front());
            void'(q_bu.pop_front());
            void'(q_keep.pop_front());
        end else if (s_hr) begin
            m_dp_valid = 0;
        end
        if (s_req) begin
            build(req_addr, int'(req_len), int'(cfg_max_len), cfg_precise);
            m_lock = cfg_lock;
        end
        #1;
        if (s_req) req_valid = 0;
        hready = rand_rdy ? (($urandom % 4) != 0) : 1'b1;
        hgrant = (grant_low > 0) ? 1'b0 : 1'b1;
        if (grant_low > 0) grant_low--;
        hrdata = s_valid ? fdat(s_addr) : '0;
        if (cycles > 150000 && !timed_out) begin
            timed_out = 1;
            fails++;
            $display("FAIL watchdog act=%0d exp=%0d", cycles, 150000);
        end
    endtask

    task automatic run(int unsigned addr, int len, int mb, bit prec, bit lock, bit rnd,
                       string tag, int chg_at);
        int n;
        cfg_max_len = 5'(mb);
        cfg_precise = prec;
        cfg_lock    = lock;
        req_addr    = addr;
        req_len     = LW'(len);
        req_valid   = 1;
        rand_rdy    = rnd;
        cur_tag     = tag;
        delivered   = 0;
        n = 0;
        do begin
            cyc();
            n++;
            if (n == chg_at) begin
                cfg_max_len = 5'd16;
                cfg_precise = ~prec;
                cfg_lock    = ~lock;
            end
        end while ((req_valid || m_busy()) && n < 3000 && !timed_out);
        if (n >= 3000) begin
            fails++;
            $display("FAIL %s request hung act=%0d exp=%0d", tag, n, 3000);
        end
        chk(delivered == len, "R6", "word count", delivered, len);
        rand_rdy = 0;
        cyc();
    endtask

    initial begin
        rst_n = 0; req_valid = 0; req_addr = 0; req_len = 0;
        cfg_max_len = 5'd4; cfg_precise = 0; cfg_lock = 0;
        hready = 1; hgrant = 1; hrdata = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // reset state: idle bus, no output, ready with valid setting (R1, R8)
        repeat (2) cyc();

        // R1: invalid settings are refused and start nothing
        cfg_max_len = 5'd5; req_addr = 32'h100; req_len = 4; req_valid = 1;
        repeat (3) cyc();
        cfg_max_len = 5'd12;
        repeat (3) cyc();
        req_valid = 0;
        cfg_max_len = 5'd4;
        cyc();

        run(32'h100, 10, 0,  0, 0, 0, "R2", -1);
        run(32'h200, 3,  1,  0, 0, 1, "R3", -1);
        run(32'h040, 23, 16, 0, 0, 1, "R4", -1);
        run(32'h080, 7,  8,  0, 0, 0, "R4", -1);
        run(32'h000, 11, 8,  1, 0, 0, "R5", -1);
        run(32'h3F8, 2,  16, 1, 0, 0, "R5", -1);
        run(32'h500, 5,  0,  1, 0, 1, "R5", -1);
        run(32'h3F0, 20, 16, 0, 0, 1, "R7", -1);
        run(32'h3E0, 40, 0,  0, 0, 1, "R7", -1);
        grant_low = 5;
        run(32'h080, 9,  4,  0, 1, 1, "R9", -1);
        run(32'h600, 12, 4,  0, 0, 0, "R10", 3);
        run(32'h000, 0,  8,  0, 0, 0, "R10", -1);
        repeat (3) cyc();

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule